// File: doc/BRIEF.md
# Three-Channel Fan Tachometer Counter

The block estimates fan speed by timing the tachometer signal against a slow reference. In each channel the rising edges of the tach input are grouped by a power-of-two divisor. The block counts the reference enable pulses that arrive during that many tach periods. A slow fan gives a large count and a fast fan gives a small one. Each finished measurement is latched into an 8-bit count register, so the value read is always the last complete measurement.

Every channel has its own count limit. When a count is latched that is larger than the limit, a sticky alarm bit is set for that channel. The alarm stays set until a clear strobe arrives. A stopped fan never ends a measurement. To handle that case, the running count stops at 255 and publishes 255 when it gets there, which sets the alarm against any limit below 255. The divisor code for each channel arrives in two parts, a 2-bit low field and a separate high bit.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every count register reads 0 and every alarm bit reads 0.
- R2: A measurement spans N consecutive tach periods, measured from rising edge to rising edge. The latched count equals the number of reference enable cycles in that span. When N times the period is a multiple of the reference spacing, the count is exact.
- R3: A channel's divisor code is {div_hi[i], div_lo[2i+1:2i]}. It selects N = 2^code, so the codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128. Code 1 selects 2, which is the usual power-on setting.
- R4: Latching a count greater than the channel's limit sets that channel's alarm bit. A count equal to the limit, or below it, does not set the alarm.
- R5: An alarm bit stays set after the fan speeds up, until clr_alarm is pulsed. If a new over-limit count is latched in the same cycle as the strobe, the bit stays set.
- R6: The running count stops at 255. When it reaches 255, 255 is latched without waiting for a tach edge. A limit of 255 therefore never raises the alarm.
- R7: A count register changes only when a measurement ends or when the running count saturates. When the tach edges stop, the last value is held until saturation.
- R8: Tach inputs pass through a two-flop synchroniser, and each rising transition yields exactly one edge. A high phase of one clock cycle is still counted.
- R9: The three channels measure, latch and alarm independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference clock enable, one cycle per reference period |
| tach_in | input | 3 | Asynchronous tach inputs, one bit per fan |
| div_lo | input | 6 | Low two divisor code bits per fan, fan i at [2i+1:2i] |
| div_hi | input | 3 | High divisor code bit per fan |
| limit | input | 24 | Count limit per fan, fan i at [8i+7:8i] |
| clr_alarm | input | 1 | One-cycle strobe that clears all alarm bits |
| count_out | output | 24 | Latched count per fan, fan i at [8i+7:8i] |
| alarm | output | 3 | Sticky slow-fan alarm bit per fan |

## Verification
The hardest case to reach from the ports is saturation while a fan is stopped. The running count has to be caught after it has left its last boundary but before it reaches 255. There is also a hold window during which the old count must still read back. The bench stops two fans whose window lengths are known. It samples once well inside the window where the old value must still be held, and once after 255 reference ticks must have passed. All eight divisor codes are swept on all three fans. The tach periods are chosen so that each window covers a whole number of reference ticks, which makes the expected counts exact.

// File: rtl/fan_tach_pkg.sv
// Package: shared helpers for the fan tachometer counter.
// Assumes divisor codes are small unsigned values (below 31).
package fan_tach_pkg;

    // Edge count index that closes a window for a given divisor code.
    function automatic int unsigned last_edge_index(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/tach_edge_detect.sv
// tach_edge_detect: brings one asynchronous tach line into the clock domain
// through two flops, then flags each rising transition for one cycle.
// Assumes the tach line stays high and low for at least one clock each.
module tach_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= tach_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising transition of the synchronised line.
    always_comb rise_o = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R8
endmodule

// File: rtl/tach_prescaler.sv
// tach_prescaler: counts synchronised tach edges and marks the edge that
// ends a window of 2^code periods. Assumes rise_i is a one-cycle pulse.
// If the code is lowered in the middle of a window, that window ends at
// the next edge.
module tach_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic [DIV_W-1:0] code_i,
    output logic             window_end_o
);
    import fan_tach_pkg::*;

    localparam int EC_W = (1 << DIV_W) - 1;

    logic [EC_W-1:0] edge_cnt_q;
    logic [EC_W-1:0] last_idx;

    // Index of the edge that completes the window.
    always_comb begin
        last_idx     = EC_W'(last_edge_index(int'(code_i)));
        window_end_o = rise_i && (edge_cnt_q >= last_idx);
    end

    // Edges seen since the previous window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_cnt_q <= '0;
        else if (rise_i)
            edge_cnt_q <= window_end_o ? '0 : edge_cnt_q + 1'b1;
    end

    AST_WINDOW_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (window_end_o && code_i != '0) |=> !window_end_o); // R3
endmodule

// File: rtl/tach_period_counter.sv
// tach_period_counter: counts reference ticks inside a window, latches
// the result at the window end or at saturation, and keeps a sticky
// over-limit alarm. Assumes window_end_i is a one-cycle pulse. The tick
// that falls in the boundary cycle belongs to the next window.
module tach_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             window_end_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             alarm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             sat_hit;
    logic             publish;
    logic [CNT_W-1:0] pub_val;

    // Decide when and what to latch.
    always_comb begin
        sat_hit = tick_i && !window_end_i && (run_q == CNT_MAX - 1'b1);
        publish = window_end_i || sat_hit;
        pub_val = window_end_i ? run_q : CNT_MAX;
    end

    // Running count of reference ticks, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (window_end_i)
            run_q <= tick_i ? CNT_W'(1) : '0;
        else if (tick_i && run_q != CNT_MAX)
            run_q <= run_q + 1'b1;
    end

    // Latched count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= '0;
        else if (publish)
            count_o <= pub_val;
    end

    // Sticky alarm; a set in the same cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_o <= 1'b0;
        else if (publish && pub_val > limit_i)
            alarm_o <= 1'b1;
        else if (clr_i)
            alarm_o <= 1'b0;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CNT_MAX && !window_end_i) |=> run_q == CNT_MAX); // R6
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !clr_i) |=> alarm_o); // R5
    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> count_o > $past(limit_i)); // R4
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_end_i && !tick_i) |=> $stable(count_o)); // R7
endmodule

// File: rtl/fan_tach_monitor.sv
// fan_tach_monitor: top level holding one tach measurement channel per fan.
// Each channel chains a synchroniser and edge detector, a divisor prescaler
// and a saturating period counter with a sticky alarm. Assumes ref_tick is
// a one-cycle enable in the clk domain.
module fan_tach_monitor #(
    parameter int NUM_FANS = 3,
    parameter int CNT_W    = 8,
    parameter int LO_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_tick,
    input  logic [NUM_FANS-1:0]       tach_in,
    input  logic [NUM_FANS*LO_W-1:0]  div_lo,
    input  logic [NUM_FANS-1:0]       div_hi,
    input  logic [NUM_FANS*CNT_W-1:0] limit,
    input  logic                      clr_alarm,
    output logic [NUM_FANS*CNT_W-1:0] count_out,
    output logic [NUM_FANS-1:0]       alarm
);
    localparam int DIV_W = LO_W + 1;

    // One independent channel per fan (R9).
    for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
        logic             rise;
        logic             win_end;
        logic [DIV_W-1:0] code;

        // Join the split divisor code fields.
        always_comb code = {div_hi[g], div_lo[g*LO_W +: LO_W]};

        tach_edge_detect u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .tach_i (tach_in[g]),
            .rise_o (rise)
        );

        tach_prescaler #(.DIV_W(DIV_W)) u_pre (
            .clk          (clk),
            .rst_n        (rst_n),
            .rise_i       (rise),
            .code_i       (code),
            .window_end_o (win_end)
        );

        tach_period_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (ref_tick),
            .window_end_i (win_end),
            .limit_i      (limit[g*CNT_W +: CNT_W]),
            .clr_i        (clr_alarm),
            .count_o      (count_out[g*CNT_W +: CNT_W]),
            .alarm_o      (alarm[g])
        );
    end
endmodule

// File: tb/fan_tach_monitor_tb.sv
module fan_tach_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NF         = 3;
    localparam int REF_DIV    = 4;
    localparam int SETTLE     = 2400;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_tick = 1'b0;
    logic [NF-1:0]    tach_in = '0;
    logic [NF*2-1:0]  div_lo = '0;
    logic [NF-1:0]    div_hi = '0;
    logic [NF*8-1:0]  limit = '1;
    logic             clr_alarm = 1'b0;
    logic [NF*8-1:0]  count_out;
    logic [NF-1:0]    alarm;

    int per [NF];
    int phase [NF];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int target [NF] = '{128, 192, 96};

    fan_tach_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
        .div_lo(div_lo), .div_hi(div_hi), .limit(limit),
        .clr_alarm(clr_alarm), .count_out(count_out), .alarm(alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus generators: reference ticks and tach waveforms, driven at negedge.
    always @(negedge clk) begin
        cyc      <= cyc + 1;
        ref_tick <= (cyc % REF_DIV) == 0;
        for (int i = 0; i < NF; i++) begin
            if (per[i] == 0) begin
                tach_in[i] <= 1'b0;
                phase[i]   <= 0;
            end else begin
                tach_in[i] <= phase[i] < per[i] / 2;
                phase[i]   <= (phase[i] >= per[i] - 1) ? 0 : phase[i] + 1;
            end
        end
    end

    function automatic int cnt_of(input int i);
        return int'(count_out[i*8 +: 8]);
    endfunction

    task automatic chk_cnt(input string req, input int i, input int exp);
        int act = cnt_of(i);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            errors++;
            $display("FAIL %s fan%0d count actual %0d expected %0d", req, i, act, exp);
        end
    endtask

    task automatic chk_alarm(input string req, input int i, input bit exp);
        checks++;
        if (alarm[i] !== exp) begin
            errors++;
            $display("FAIL %s fan%0d alarm actual %0b expected %0b", req, i, alarm[i], exp);
        end
    endtask

    task automatic set_code(input int i, input int code);
        div_lo[i*2 +: 2] = 2'(code);
        div_hi[i]        = 1'(code >> 2);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_alarm = 1'b1;
        @(negedge clk) clr_alarm = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cyc > WATCHDOG);
        errors++;
        $display("FAIL watchdog expired actual %0d expected below %0d", cyc, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NF; i++) begin per[i] = 0; phase[i] = 0; end
        wait_cyc(5);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(3);
        // R1: reset state
        for (int i = 0; i < NF; i++) begin
            chk_cnt("R1", i, 0);
            chk_alarm("R1", i, 1'b0);
        end

        // R2 R3 R9: sweep all divisor codes with distinct speeds per fan,
        // limits high so no alarm; code 7 on fan2 gives a 1-cycle high phase (R8).
        limit = {8'd250, 8'd250, 8'd250};
        for (int code = 0; code < 8; code++) begin
            @(negedge clk);
            for (int i = 0; i < NF; i++) begin
                set_code(i, code);
                per[i] = (target[i] * REF_DIV) >> code;
            end
            wait_cyc(SETTLE);
            for (int i = 0; i < NF; i++)
                chk_cnt(code == 7 ? "R2/R3/R8" : "R2/R3/R9", i, target[i]);
        end
        for (int i = 0; i < NF; i++) chk_alarm("R4 under limit", i, 1'b0);

        // R4: over-limit sets alarm, equal does not; divisor code 1 means 2.
        @(negedge clk);
        for (int i = 0; i < NF; i++) begin
            set_code(i, 1);
            per[i] = target[i] * REF_DIV / 2;
        end
        limit = {8'd95, 8'd192, 8'd127};
        pulse_clr();
        wait_cyc(SETTLE);
        chk_cnt("R3 code1", 1, 192);
        chk_alarm("R4", 0, 1'b1);
        chk_alarm("R4 equal", 1, 1'b0);
        chk_alarm("R4", 2, 1'b1);

        // R5: fan0 speeds up below its limit, alarm stays until cleared.
        per[0] = 128;
        wait_cyc(SETTLE);
        chk_cnt("R5 faster", 0, 64);
        chk_alarm("R5 sticky", 0, 1'b1);
        pulse_clr();
        wait_cyc(SETTLE);
        chk_alarm("R5 cleared", 0, 1'b0);
        chk_alarm("R5 reset again", 2, 1'b1);

        // R6 R7: stop fans 0 and 1; old counts held, then saturate to 255.
        limit = {8'd95, 8'd200, 8'd255};
        @(negedge clk);
        per[0] = 0;
        per[1] = 0;
        wait_cyc(50);
        chk_cnt("R7 hold", 0, 64);
        chk_cnt("R7 hold", 1, 192);
        chk_alarm("R7 hold", 1, 1'b0);
        wait_cyc(1200);
        chk_cnt("R6 saturate", 0, 255);
        chk_cnt("R6 saturate", 1, 255);
        chk_alarm("R6 limit 255", 0, 1'b0);
        chk_alarm("R6 over limit", 1, 1'b1);
        chk_cnt("R9 untouched", 2, 96);

        // R2: fan0 restarts and measures again.
        per[0] = 256;
        wait_cyc(SETTLE);
        chk_cnt("R2 restart", 0, 128);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule